// File: doc/BRIEF.md
# Instruction Key-Chain Sequencer

This block decides whether the next instruction may run on a processor whose register file stays encrypted between instructions. Each instruction arrives already decrypted. It carries a flag that says whether its authentication passed, an opcode, a 32-bit argument or target label, a 128-bit previous-key field and up to two 128-bit next-key fields. The sequencer holds one chain key. It accepts an instruction only if the instruction's previous key equals that chain key. Each accepted instruction then selects the next chain key and the next instruction pointer, and the choice depends on the instruction class.

Jumps and calls take their next key from an external key-derivation unit, which computes a keyed MAC of the target label under the master key. The request goes out on a valid/ready port and the key returns on a response port. A call also draws a fresh random return key from an external generator. It pushes that key, together with the return address, onto an internal call stack. A return pops the stack to restore both. Any fault stops the sequencer until reset. The faults are a failed authentication, a key mismatch, an unknown opcode, or a call stack that is full on a call or empty on a return. The block contains no cipher, no MAC and no execution datapath.

Top module: `keychain_seq`

## Requirements
- R1: After reset the chain key equals `master_key`, `ip` is 0, `halted` is 0, `halt_cause` is 0, and `instr_ready` is 1.
- R2: A sequential instruction (opcode 0x00 to 0x7F) whose previous key matches the chain key commits in the accepting cycle. The chain key becomes `instr_knext_a`, `ip` increments by one and `retire` pulses.
- R3: If the previous key differs from the chain key, the block sets `halted` with cause 2 and leaves the chain key and `ip` unchanged. The halt is sticky until reset, and while it is set `instr_ready` stays 0.
- R4: An instruction presented with `instr_auth_ok` low halts the block with cause 1. This cause wins over every other fault.
- R5: For a conditional branch (0x80), when `br_taken` is 1 the chain key becomes `instr_knext_a` and `ip` loads the argument. When `br_taken` is 0 the chain key becomes `instr_knext_b` and `ip` increments.
- R6: A jump (0x81) raises `deriv_req_valid` with the argument on `deriv_req_label`. It holds both until `deriv_req_ready`, then waits for `deriv_rsp_valid`. Only then does the chain key become `deriv_rsp_key` and `ip` load the argument. Neither changes earlier.
- R7: A call (0x82) first obtains the derived key for its target and then asserts `rng_req` until `rng_valid`. On `rng_valid` it pushes the pair {ip+1, `rng_key`}, the chain key becomes the derived key and `ip` loads the target.
- R8: A return (0x83) pops the most recently pushed pair. The chain key becomes the stored random key and `ip` becomes the stored return address, so nested calls unwind in last-in first-out order.
- R9: Opcodes 0x84 to 0xFF halt the block with cause 3.
- R10: A call while the stack already holds `STACK_DEPTH` entries, or a return while it is empty, halts the block with cause 4.
- R11: `instr_ready` is 0 in every wait state, so a new instruction is accepted only after the previous one has committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| master_key | input | KEY_W | Master key; loaded as the chain key at reset |
| instr_valid | input | 1 | Instruction fields are valid |
| instr_ready | output | 1 | Sequencer can accept an instruction |
| instr_auth_ok | input | 1 | Authentication of the instruction passed |
| instr_op | input | OP_W | Opcode |
| instr_arg | input | ARG_W | Argument or target label |
| instr_kprev | input | KEY_W | Previous-key field |
| instr_knext_a | input | KEY_W | Next key (taken key for branches) |
| instr_knext_b | input | KEY_W | Not-taken key for branches |
| br_taken | input | 1 | Branch condition outcome |
| deriv_req_valid | output | 1 | Key-derivation request valid |
| deriv_req_ready | input | 1 | Derivation unit accepts the request |
| deriv_req_label | output | ARG_W | Label to derive a key from |
| deriv_rsp_valid | input | 1 | Derived key is valid |
| deriv_rsp_key | input | KEY_W | Derived key |
| rng_req | output | 1 | Random key requested |
| rng_valid | input | 1 | Random key is valid |
| rng_key | input | KEY_W | Random key |
| chain_key | output | KEY_W | Current chain key |
| ip | output | ARG_W | Current instruction pointer |
| retire | output | 1 | One-cycle pulse per committed instruction |
| halted | output | 1 | Sticky halt flag |
| halt_cause | output | 3 | 0 none, 1 authentication, 2 key mismatch, 3 bad opcode, 4 stack fault |

## Verification
The assertions assume several things about the environment. `master_key` is stable from reset onward. The derivation unit answers only after it has taken a request, and the random source drives `rng_valid` only while `rng_req` is high. The assertions also assume that no response arrives in a cycle where the sequencer is not waiting for one. The bench's responders obey these rules by construction. The derivation responder raises ready only on an outstanding request and returns its key after the handshake. The random responder answers only while `rng_req` is asserted. The random program draws each previous key from the modelled chain key, and it chooses calls and returns only when the modelled stack depth allows them. Faults therefore appear only in the directed cases.

// File: rtl/keychain_pkg.sv
package keychain_pkg;

  localparam logic [7:0] OPC_BRANCH = 8'h80;
  localparam logic [7:0] OPC_JUMP   = 8'h81;
  localparam logic [7:0] OPC_CALL   = 8'h82;
  localparam logic [7:0] OPC_RETURN = 8'h83;

  typedef enum logic [2:0] {
    CLS_SEQ  = 3'd0,
    CLS_BR   = 3'd1,
    CLS_JMP  = 3'd2,
    CLS_CALL = 3'd3,
    CLS_RET  = 3'd4,
    CLS_BAD  = 3'd5
  } op_class_e;

  typedef enum logic [2:0] {
    HALT_NONE   = 3'd0,
    HALT_INTEG  = 3'd1,
    HALT_CHAIN  = 3'd2,
    HALT_OPCODE = 3'd3,
    HALT_STACK  = 3'd4
  } halt_cause_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_DREQ  = 3'd1,
    ST_DWAIT = 3'd2,
    ST_RWAIT = 3'd3,
    ST_POP   = 3'd4,
    ST_HALT  = 3'd5
  } seq_state_e;

endpackage

// File: rtl/kc_decode.sv
module kc_decode
  import keychain_pkg::*;
#(
  parameter int OP_W = 8
) (
  input  logic [OP_W-1:0] op,
  output op_class_e       cls
);

  localparam int UPPER_W = (OP_W > 8) ? OP_W - 8 : 1;

  logic upper_zero;

  generate
    if (OP_W > 8) begin : g_wide
      assign upper_zero = (op[OP_W-1:8] == UPPER_W'(0));
    end else begin : g_narrow
      assign upper_zero = 1'b1;
    end
  endgenerate

  always_comb begin
    cls = CLS_BAD;
    if (upper_zero) begin
      if (!op[7]) begin
        cls = CLS_SEQ;
      end else begin
        unique case (op[7:0])
          OPC_BRANCH: cls = CLS_BR;
          OPC_JUMP:   cls = CLS_JMP;
          OPC_CALL:   cls = CLS_CALL;
          OPC_RETURN: cls = CLS_RET;
          default:    cls = CLS_BAD;
        endcase
      end
    end
  end

endmodule

// File: rtl/kc_call_stack.sv
module kc_call_stack #(
  parameter int DEPTH = 4,
  parameter int IP_W  = 32,
  parameter int KEY_W = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [IP_W-1:0]  push_ip,
  input  logic [KEY_W-1:0] push_key,
  input  logic             pop,
  output logic [IP_W-1:0]  top_ip,
  output logic [KEY_W-1:0] top_key,
  output logic             full,
  output logic             empty
);

  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int ENT_W = IP_W + KEY_W;

  logic [ENT_W-1:0] mem [DEPTH];
  logic [ENT_W-1:0] rd_q;
  logic [AW:0]      sp_q;
  logic [AW:0]      sp_dec;

  assign sp_dec = sp_q - (AW+1)'(1);
  assign full   = (sp_q == (AW+1)'(DEPTH));
  assign empty  = (sp_q == '0);

  // Memory port: no reset, synchronous read, so it maps onto block RAM.
  always_ff @(posedge clk) begin
    if (push) begin
      mem[sp_q[AW-1:0]] <= {push_ip, push_key};
    end
    if (pop) begin
      rd_q <= mem[sp_dec[AW-1:0]];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sp_q <= '0;
    end else if (push) begin
      sp_q <= sp_q + (AW+1)'(1);
    end else if (pop) begin
      sp_q <= sp_dec;
    end
  end

  assign top_ip  = rd_q[ENT_W-1:KEY_W];
  assign top_key = rd_q[KEY_W-1:0];

  AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (rst)
    push |-> !full); // R10
  AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty); // R10
  AST_PUSH_POP_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(push && pop)); // R11

endmodule

// File: rtl/kc_halt_latch.sv
module kc_halt_latch
  import keychain_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        set,
  input  halt_cause_e cause_in,
  output logic        halted,
  output halt_cause_e cause
);

  always_ff @(posedge clk) begin
    if (rst) begin
      halted <= 1'b0;
      cause  <= HALT_NONE;
    end else if (set && !halted) begin
      halted <= 1'b1;
      cause  <= cause_in;
    end
  end

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted && $stable(cause)); // R3
  AST_HALT_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    halted |-> cause != HALT_NONE); // R3

endmodule

// File: rtl/keychain_seq.sv
module keychain_seq
  import keychain_pkg::*;
#(
  parameter int OP_W        = 8,
  parameter int ARG_W       = 32,
  parameter int KEY_W       = 128,
  parameter int STACK_DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [KEY_W-1:0] master_key,
  input  logic             instr_valid,
  output logic             instr_ready,
  input  logic             instr_auth_ok,
  input  logic [OP_W-1:0]  instr_op,
  input  logic [ARG_W-1:0] instr_arg,
  input  logic [KEY_W-1:0] instr_kprev,
  input  logic [KEY_W-1:0] instr_knext_a,
  input  logic [KEY_W-1:0] instr_knext_b,
  input  logic             br_taken,
  output logic             deriv_req_valid,
  input  logic             deriv_req_ready,
  output logic [ARG_W-1:0] deriv_req_label,
  input  logic             deriv_rsp_valid,
  input  logic [KEY_W-1:0] deriv_rsp_key,
  output logic             rng_req,
  input  logic             rng_valid,
  input  logic [KEY_W-1:0] rng_key,
  output logic [KEY_W-1:0] chain_key,
  output logic [ARG_W-1:0] ip,
  output logic             retire,
  output logic             halted,
  output logic [2:0]       halt_cause
);

  seq_state_e       state_q;
  logic [KEY_W-1:0] chain_key_q;
  logic [ARG_W-1:0] ip_q;
  logic [ARG_W-1:0] lat_arg_q;
  op_class_e        lat_cls_q;
  logic [KEY_W-1:0] dkey_q;
  logic             retire_q;

  op_class_e        cls;
  halt_cause_e      fault;
  halt_cause_e      cause_q;
  logic             accept;
  logic             go;
  logic             stk_push;
  logic             stk_pop;
  logic             stk_full;
  logic             stk_empty;
  logic [ARG_W-1:0] stk_top_ip;
  logic [KEY_W-1:0] stk_top_key;
  logic [ARG_W-1:0] ip_inc;

  assign instr_ready = (state_q == ST_IDLE);
  assign accept      = instr_valid && instr_ready;
  assign ip_inc      = ip_q + ARG_W'(1);

  kc_decode #(.OP_W(OP_W)) u_decode (
    .op  (instr_op),
    .cls (cls)
  );

  // Fault priority: authentication, chain key, opcode, stack.
  always_comb begin
    fault = HALT_NONE;
    if (!instr_auth_ok) begin
      fault = HALT_INTEG;
    end else if (instr_kprev != chain_key_q) begin
      fault = HALT_CHAIN;
    end else if (cls == CLS_BAD) begin
      fault = HALT_OPCODE;
    end else if ((cls == CLS_CALL && stk_full) || (cls == CLS_RET && stk_empty)) begin
      fault = HALT_STACK;
    end
  end

  assign go       = accept && (fault == HALT_NONE);
  assign stk_pop  = go && (cls == CLS_RET);
  assign stk_push = (state_q == ST_RWAIT) && rng_valid;

  kc_halt_latch u_halt (
    .clk      (clk),
    .rst      (rst),
    .set      (accept && (fault != HALT_NONE)),
    .cause_in (fault),
    .halted   (halted),
    .cause    (cause_q)
  );

  kc_call_stack #(
    .DEPTH (STACK_DEPTH),
    .IP_W  (ARG_W),
    .KEY_W (KEY_W)
  ) u_stack (
    .clk      (clk),
    .rst      (rst),
    .push     (stk_push),
    .push_ip  (ip_inc),
    .push_key (rng_key),
    .pop      (stk_pop),
    .top_ip   (stk_top_ip),
    .top_key  (stk_top_key),
    .full     (stk_full),
    .empty    (stk_empty)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      chain_key_q <= master_key;
      ip_q        <= '0;
      lat_arg_q   <= '0;
      lat_cls_q   <= CLS_SEQ;
      dkey_q      <= '0;
      retire_q    <= 1'b0;
    end else begin
      retire_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            if (fault != HALT_NONE) begin
              state_q <= ST_HALT;
            end else begin
              lat_arg_q <= instr_arg;
              lat_cls_q <= cls;
              unique case (cls)
                CLS_SEQ: begin
                  chain_key_q <= instr_knext_a;
                  ip_q        <= ip_inc;
                  retire_q    <= 1'b1;
                end
                CLS_BR: begin
                  if (br_taken) begin
                    chain_key_q <= instr_knext_a;
                    ip_q        <= instr_arg;
                  end else begin
                    chain_key_q <= instr_knext_b;
                    ip_q        <= ip_inc;
                  end
                  retire_q <= 1'b1;
                end
                CLS_JMP, CLS_CALL: state_q <= ST_DREQ;
                CLS_RET:           state_q <= ST_POP;
                default:           state_q <= ST_HALT;
              endcase
            end
          end
        end
        ST_DREQ: begin
          if (deriv_req_ready) state_q <= ST_DWAIT;
        end
        ST_DWAIT: begin
          if (deriv_rsp_valid) begin
            if (lat_cls_q == CLS_JMP) begin
              chain_key_q <= deriv_rsp_key;
              ip_q        <= lat_arg_q;
              retire_q    <= 1'b1;
              state_q     <= ST_IDLE;
            end else begin
              dkey_q  <= deriv_rsp_key;
              state_q <= ST_RWAIT;
            end
          end
        end
        ST_RWAIT: begin
          if (rng_valid) begin
            chain_key_q <= dkey_q;
            ip_q        <= lat_arg_q;
            retire_q    <= 1'b1;
            state_q     <= ST_IDLE;
          end
        end
        ST_POP: begin
          chain_key_q <= stk_top_key;
          ip_q        <= stk_top_ip;
          retire_q    <= 1'b1;
          state_q     <= ST_IDLE;
        end
        ST_HALT: state_q <= ST_HALT;
        default: state_q <= ST_HALT;
      endcase
    end
  end

  assign deriv_req_valid = (state_q == ST_DREQ);
  assign deriv_req_label = lat_arg_q;
  assign rng_req         = (state_q == ST_RWAIT);
  assign chain_key       = chain_key_q;
  assign ip              = ip_q;
  assign retire          = retire_q;
  assign halt_cause      = cause_q;

  AST_SEQ_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (go && cls == CLS_SEQ) |=> (ip_q == $past(ip_q) + ARG_W'(1)) && retire); // R2
  AST_MISMATCH_HALTS: assert property (@(posedge clk) disable iff (rst)
    (accept && instr_auth_ok && instr_kprev != chain_key_q) |=> halted && $stable(ip_q)); // R3
  AST_HALTED_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    halted |-> !instr_ready); // R3
  AST_AUTH_FIRST: assert property (@(posedge clk) disable iff (rst)
    (accept && !instr_auth_ok) |=> halted && halt_cause == 3'd1); // R4
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    (deriv_req_valid && !deriv_req_ready) |=> deriv_req_valid && $stable(deriv_req_label)); // R6
  AST_WAIT_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (deriv_req_valid || (state_q == ST_DWAIT && !deriv_rsp_valid)) |=> $stable(chain_key_q) && $stable(ip_q)); // R6
  AST_BAD_OPCODE: assert property (@(posedge clk) disable iff (rst)
    (accept && instr_auth_ok && instr_kprev == chain_key_q && cls == CLS_BAD) |=> halt_cause == 3'd3); // R9
  AST_WAIT_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    (deriv_req_valid || rng_req) |-> !instr_ready); // R11

endmodule

// File: tb/keychain_seq_tb.sv
`timescale 1ns/1ps
module keychain_seq_tb;

  localparam int SDEPTH = 4;
  localparam logic [127:0] MKEY = 128'h0f1e2d3c_4b5a6978_8796a5b4_c3d2e1f0;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         instr_valid = 1'b0;
  logic         instr_ready;
  logic         instr_auth_ok = 1'b1;
  logic [7:0]   instr_op = '0;
  logic [31:0]  instr_arg = '0;
  logic [127:0] instr_kprev = '0, instr_knext_a = '0, instr_knext_b = '0;
  logic         br_taken = 1'b0;
  logic         deriv_req_valid, deriv_req_ready;
  logic [31:0]  deriv_req_label;
  logic         deriv_rsp_valid;
  logic [127:0] deriv_rsp_key;
  logic         rng_req, rng_valid;
  logic [127:0] rng_key;
  logic [127:0] chain_key;
  logic [31:0]  ip;
  logic         retire, halted;
  logic [2:0]   halt_cause;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // model state
  logic [127:0] m_key;
  logic [31:0]  m_ip;
  bit           m_halt;
  logic [2:0]   m_cause;
  logic [31:0]  m_sip [SDEPTH];
  logic [127:0] m_skey [SDEPTH];
  int           m_sp;
  int           m_rng_n;
  int           rsp_rng_n;

  always #4 clk = ~clk;

  keychain_seq #(.STACK_DEPTH(SDEPTH)) u_dut (
    .clk(clk), .rst(rst), .master_key(MKEY),
    .instr_valid(instr_valid), .instr_ready(instr_ready), .instr_auth_ok(instr_auth_ok),
    .instr_op(instr_op), .instr_arg(instr_arg), .instr_kprev(instr_kprev),
    .instr_knext_a(instr_knext_a), .instr_knext_b(instr_knext_b), .br_taken(br_taken),
    .deriv_req_valid(deriv_req_valid), .deriv_req_ready(deriv_req_ready),
    .deriv_req_label(deriv_req_label), .deriv_rsp_valid(deriv_rsp_valid),
    .deriv_rsp_key(deriv_rsp_key), .rng_req(rng_req), .rng_valid(rng_valid),
    .rng_key(rng_key), .chain_key(chain_key), .ip(ip), .retire(retire),
    .halted(halted), .halt_cause(halt_cause)
  );

  function automatic logic [127:0] derive_key(input logic [31:0] lbl);
    return {lbl, ~lbl, lbl ^ 32'h5a5a_5a5a, lbl + 32'h0123_4567} ^ MKEY;
  endfunction

  function automatic logic [127:0] rng_val(input int n);
    logic [31:0] v = 32'(n);
    return {v ^ 32'hdead_beef, v, ~v, v + 32'h7777_0000};
  endfunction

  function automatic logic [127:0] rand_key();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic compare(input string req);
    chk(chain_key == m_key, req, "chain_key", chain_key, m_key);
    chk(ip == m_ip, req, "ip", 128'(ip), 128'(m_ip));
    chk(halted == m_halt, req, "halted", 128'(halted), 128'(m_halt));
    chk(halt_cause == m_cause, req, "halt_cause", 128'(halt_cause), 128'(m_cause));
  endtask

  // derivation responder
  initial begin : deriv_resp
    bit pend = 0; int dly = 0; int gap = 0; logic [31:0] lbl = '0;
    deriv_req_ready = 0; deriv_rsp_valid = 0; deriv_rsp_key = '0;
    forever begin
      @(negedge clk);
      deriv_req_ready = 0;
      deriv_rsp_valid = 0;
      if (rst) begin
        pend = 0;
      end else if (pend) begin
        if (dly == 0) begin
          deriv_rsp_valid = 1;
          deriv_rsp_key = derive_key(lbl);
          pend = 0;
        end else dly--;
      end else if (deriv_req_valid) begin
        if (gap == 0) begin
          deriv_req_ready = 1;
          lbl = deriv_req_label;
          pend = 1;
          dly = $urandom % 3;
          gap = $urandom % 3;
        end else gap--;
      end
    end
  end

  // random key responder
  initial begin : rng_resp
    int gap = 0;
    rng_valid = 0; rng_key = '0;
    forever begin
      @(negedge clk);
      rng_valid = 0;
      if (rst) rsp_rng_n = 0;
      else if (rng_req) begin
        if (gap == 0) begin
          rng_valid = 1;
          rng_key = rng_val(rsp_rng_n);
          rsp_rng_n++;
          gap = $urandom % 3;
        end else gap--;
      end
    end
  end

  task automatic do_reset();
    rst = 1;
    instr_valid = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    m_key = MKEY; m_ip = '0; m_halt = 0; m_cause = 3'd0; m_sp = 0; m_rng_n = 0;
    @(negedge clk);
  endtask

  task automatic model_step(input logic [7:0] op, input logic [31:0] arg,
                            input logic [127:0] kp, ka, kb, input bit auth, input bit tk);
    logic [2:0] f = 3'd0;
    if (!auth) f = 3'd1;
    else if (kp != m_key) f = 3'd2;
    else if (op > 8'h83) f = 3'd3;
    else if ((op == 8'h82 && m_sp == SDEPTH) || (op == 8'h83 && m_sp == 0)) f = 3'd4;
    if (f != 3'd0) begin
      m_halt = 1; m_cause = f;
    end else if (op < 8'h80) begin
      m_key = ka; m_ip = m_ip + 1;
    end else if (op == 8'h80) begin
      if (tk) begin m_key = ka; m_ip = arg; end
      else begin m_key = kb; m_ip = m_ip + 1; end
    end else if (op == 8'h81) begin
      m_key = derive_key(arg); m_ip = arg;
    end else if (op == 8'h82) begin
      m_sip[m_sp] = m_ip + 1; m_skey[m_sp] = rng_val(m_rng_n);
      m_rng_n++; m_sp++;
      m_key = derive_key(arg); m_ip = arg;
    end else begin
      m_sp--;
      m_key = m_skey[m_sp]; m_ip = m_sip[m_sp];
    end
  endtask

  task automatic issue(input logic [7:0] op, input logic [31:0] arg,
                       input logic [127:0] kp, ka, kb, input bit auth, input bit tk,
                       input string req);
    logic [127:0] k0; logic [31:0] ip0; bit stable_ok; bit saw_wait; bit clean;
    @(negedge clk);
    while (!instr_ready) @(negedge clk);
    k0 = chain_key; ip0 = ip;
    clean = auth && (kp == m_key);
    instr_op = op; instr_arg = arg; instr_kprev = kp; instr_knext_a = ka;
    instr_knext_b = kb; instr_auth_ok = auth; br_taken = tk; instr_valid = 1;
    model_step(op, arg, kp, ka, kb, auth, tk);
    @(negedge clk);
    instr_valid = 0;
    stable_ok = 1; saw_wait = 0;
    while (!instr_ready && !halted) begin
      saw_wait = 1;
      if (chain_key != k0 || ip != ip0) stable_ok = 0;
      @(negedge clk);
    end
    if (clean && (op == 8'h81 || (op == 8'h82 && m_sp > 0 && !m_halt))) begin
      chk(saw_wait, "R11", "ready low while waiting", 128'(saw_wait), 128'(1));
      chk(stable_ok, "R6", "key and ip frozen before response", 128'(stable_ok), 128'(1));
    end
    compare(req);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R11 watchdog expired: actual hung, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd1234));
    do_reset();
    // R1 reset state
    compare("R1");
    chk(instr_ready == 1, "R1", "instr_ready", 128'(instr_ready), 128'(1));

    // R2 first instruction chained from master key
    issue(8'h05, 32'h0, MKEY, rand_key(), '0, 1, 0, "R2");
    // R5 branch taken and not taken
    issue(8'h80, 32'h40, m_key, rand_key(), rand_key(), 1, 1, "R5");
    issue(8'h80, 32'h99, m_key, rand_key(), rand_key(), 1, 0, "R5");
    // R6 jump
    issue(8'h81, 32'h1000, m_key, '0, '0, 1, 0, "R6");
    // R7/R8 nested calls fill stack then unwind
    for (int i = 0; i < SDEPTH; i++) issue(8'h82, 32'h2000 + 32'(i * 16), m_key, '0, '0, 1, 0, "R7");
    for (int i = 0; i < SDEPTH; i++) issue(8'h83, 32'h0, m_key, '0, '0, 1, 0, "R8");

    // R10 call on full stack
    for (int i = 0; i < SDEPTH; i++) issue(8'h82, 32'h3000 + 32'(i), m_key, '0, '0, 1, 0, "R7");
    issue(8'h82, 32'h3100, m_key, '0, '0, 1, 0, "R10");

    // R10 return on empty stack
    do_reset();
    issue(8'h83, 32'h0, MKEY, '0, '0, 1, 0, "R10");

    // R4 authentication fault wins over key mismatch
    do_reset();
    issue(8'h01, 32'h0, ~MKEY, rand_key(), '0, 0, 0, "R4");

    // R3 key mismatch, sticky, later instructions ignored
    do_reset();
    issue(8'h02, 32'h0, MKEY, rand_key(), '0, 1, 0, "R2");
    issue(8'h03, 32'h0, ~m_key, rand_key(), '0, 1, 0, "R3");
    @(negedge clk);
    instr_op = 8'h04; instr_kprev = m_key; instr_knext_a = rand_key();
    instr_auth_ok = 1; instr_valid = 1;
    repeat (5) @(negedge clk);
    instr_valid = 0;
    chk(instr_ready == 0, "R3", "ready while halted", 128'(instr_ready), 128'(0));
    compare("R3");

    // R9 unknown opcodes
    do_reset();
    issue(8'h84, 32'h0, MKEY, rand_key(), '0, 1, 0, "R9");
    do_reset();
    issue(8'hff, 32'h0, MKEY, rand_key(), '0, 1, 0, "R9");

    // constrained random legal programs
    do_reset();
    for (int n = 0; n < 400; n++) begin
      int r = $urandom % 10;
      logic [31:0] a = $urandom;
      if (r < 4 || (r == 7 && m_sp == SDEPTH) || (r >= 8 && m_sp == 0))
        issue(8'($urandom % 128), a, m_key, rand_key(), '0, 1, 0, "R2");
      else if (r < 6)
        issue(8'h80, a, m_key, rand_key(), rand_key(), 1, bit'($urandom % 2), "R5");
      else if (r == 6)
        issue(8'h81, a, m_key, '0, '0, 1, 0, "R6");
      else if (r == 7)
        issue(8'h82, a, m_key, '0, '0, 1, 0, "R7");
      else
        issue(8'h83, a, m_key, '0, '0, 1, 0, "R8");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule